// File: doc/BRIEF.md
# Debug Control and Status Register Pair

This block keeps the debug control word and the debug status word of an x86-style core. Both are 32-bit registers. Software reaches them through a move-to/move-from port that takes a 3-bit register index. Indices 0 to 3 name the breakpoint address registers. Those live elsewhere, so here they read as zero and ignore writes. Index 6 selects the status word and index 7 the control word. Indices 4 and 5 alias 6 and 7, unless the debug-extensions enable is high. In that case an access to either alias is refused with an invalid-opcode pulse. While the general-detect lock in the control word is set, every access is refused. The refused access sets the access-detect flag in the status word and pulses a debug-exception output.

Three core events also act on the pair:
- Debug exception entry merges a pending-event word into the status word and drops the lock.
- A task switch clears the local enables.
- A mode-entry force-load writes the control word directly, bypassing the lock.

Every control update obeys the same hardwired bits. A combinational flag tells the core when an instruction-fetch breakpoint may be armed.

The parameter `NEWER_GEN` picks the generation. The default of 1 is the newer one: control bits 15, 14 and 12 read 0 and status bit 12 reads 0. With `NEWER_GEN` = 0 those control bits are writable, status bit 12 is writable and resets to 1, and the status reset value is 0xFFFF1FF0. The requirements below are stated for the default.

Top module: `dbg_ctlsts_regs`

## Requirements
- R1: After reset the control word is 0x00000400, the status word is 0xFFFF0FF0, the read data is 0, and the strobes and the breakpoint flag are 0.
- R2: A granted write to control (index 7, or 5 when aliasing is allowed) stores (wdata AND 0xFFFF2FFF) OR 0x00000400. Bit 10 always reads 1 and bits 15, 14 and 12 always read 0. The new value is visible the cycle after the access.
- R3: A granted write to status (index 6, or 4 when aliasing is allowed) replaces only bits 3:0 and 15:13 with the write data. Bit 12 stays 0, and bits 31:16 and 11:4 stay 1.
- R4: When control bit 13 (lock) is set, any access with any index is refused. On the next cycle fault_db pulses for one cycle, status bit 13 is set, no read strobe occurs and neither register takes the write.
- R5: Exception entry replaces status bits 3:0 and 15:13 with the same bits of the event word, keeping bit 12 at 0. It also clears control bit 13.
- R6: A task switch clears control bits 0, 2, 4, 6 and 8 (mask 0x155) and keeps every other bit.
- R7: With debug extensions enabled, an unlocked access to index 4 or 5 gives a one-cycle fault_ud pulse and has no other effect. With them disabled, 4 and 5 act as 6 and 7. fault_ud and fault_db are never high together.
- R8: The breakpoint flag is high exactly when any of control bits 7:0 is set and at least one 2-bit type field at bits 17:16, 21:20, 25:24 or 29:28 equals 00.
- R9: A granted read returns the selected value (0 for indices 0 to 3) on acc_rdata with a one-cycle acc_rvalid pulse, both on the next cycle. acc_rdata holds its value between reads. A write to indices 0 to 3 changes nothing.
- R10: A force-load stores (force_value AND 0xFFFF2FFF) OR 0x400 in control, whether or not the lock is set.
- R11: Within one cycle the effects apply in this order: the port access, then exception entry, then task switch, then force-load. Each later step acts on the result of the earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_ext_en | input | 1 | Debug extensions enable; turns indices 4 and 5 into faults |
| acc_valid | input | 1 | Port access strobe |
| acc_write | input | 1 | 1 = move to register, 0 = move from register |
| acc_index | input | 3 | Debug register index 0 to 7 |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, held between reads |
| acc_rvalid | output | 1 | One-cycle pulse for a granted read |
| fault_db | output | 1 | One-cycle debug-exception pulse for a locked access |
| fault_ud | output | 1 | One-cycle invalid-opcode pulse for a refused alias |
| exc_entry | input | 1 | Debug exception entry |
| exc_events | input | 32 | Pending event word merged on exception entry |
| task_switch | input | 1 | Task switch event |
| force_load | input | 1 | Mode-entry force-load of the control word |
| force_value | input | 32 | Value for the force-load |
| ctl_value | output | 32 | Current control word |
| sts_value | output | 32 | Current status word |
| bp_check_needed | output | 1 | Instruction breakpoint check required |

## Verification
The bench goes after the lock. A design that checked the lock after alias decoding would raise the wrong fault on a locked index-4 access. One that forgot to set the access-detect bit would leave the status word unchanged. It collides port writes with task switches and exception entries in the same cycle. A wrong ordering leaves local enables set, or lets a locked control written with GD come back. It writes all-ones patterns to both registers, which exposes any hardwired bit that leaks through a write, a merge or a force-load. It steps type fields between 00 and non-zero with and without enables, so that a flag decoded from the wrong field positions toggles at the wrong time.

// File: rtl/dbg_regs_pkg.sv
package dbg_regs_pkg;
    localparam int REG_W = 32;
    localparam int IDX_W = 3;

    typedef logic [REG_W-1:0] word_t;

    localparam int LOCK_BIT      = 13;
    localparam int ACC_FLAG_BIT  = 13;
    localparam int EN_BITS       = 8;
    localparam int TYPE_LSB      = 16;
    localparam int TYPE_STRIDE   = 4;
    localparam int TYPE_W        = 2;

    localparam word_t CTL_SET_ONES   = 32'h0000_0400;
    localparam word_t TASK_CLR_MASK  = 32'h0000_0155;
    localparam word_t STS_FIELD_MASK = 32'h0000_F00F;

    typedef struct packed {
        word_t ctl;
        word_t sts;
        word_t rdata;
        logic  rvalid;
        logic  fault_db;
        logic  fault_ud;
    } regs_t;
endpackage

// File: rtl/dbg_gen_masks.sv
module dbg_gen_masks
    import dbg_regs_pkg::*;
#(
    parameter bit NEWER_GEN = 1'b1
) (
    output word_t ctl_keep_mask,
    output word_t sts_take_mask,
    output word_t sts_reset_val
);
    generate
        if (NEWER_GEN) begin : g_newer
            assign ctl_keep_mask = 32'hFFFF_2FFF;
            assign sts_take_mask = 32'h0000_E00F;
            assign sts_reset_val = 32'hFFFF_0FF0;
        end else begin : g_older
            assign ctl_keep_mask = 32'hFFFF_FFFF;
            assign sts_take_mask = 32'h0000_F00F;
            assign sts_reset_val = 32'hFFFF_1FF0;
        end
    endgenerate
endmodule

// File: rtl/dbg_port_decode.sv
module dbg_port_decode
    import dbg_regs_pkg::*;
(
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_index,
    input  logic             lock_set,
    input  logic             ext_en,
    output logic             grant,
    output logic             refuse_db,
    output logic             refuse_ud,
    output logic             hit_sts,
    output logic             hit_ctl
);
    localparam logic [IDX_W-1:0] IDX_STS_ALIAS = 3'd4;
    localparam logic [IDX_W-1:0] IDX_CTL_ALIAS = 3'd5;
    localparam logic [IDX_W-1:0] IDX_STS       = 3'd6;
    localparam logic [IDX_W-1:0] IDX_CTL       = 3'd7;

    logic is_alias;

    always_comb begin
        is_alias  = (acc_index == IDX_STS_ALIAS) || (acc_index == IDX_CTL_ALIAS);
        refuse_db = acc_valid && lock_set;
        refuse_ud = acc_valid && !lock_set && ext_en && is_alias;
        grant     = acc_valid && !lock_set && !(ext_en && is_alias);
        hit_sts   = (acc_index == IDX_STS) || (acc_index == IDX_STS_ALIAS);
        hit_ctl   = (acc_index == IDX_CTL) || (acc_index == IDX_CTL_ALIAS);
    end
endmodule

// File: rtl/dbg_bp_watch.sv
module dbg_bp_watch
    import dbg_regs_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic [EN_BITS-1:0]          enables,
    input  logic [NUM_SLOTS*TYPE_W-1:0] type_codes,
    output logic                        check_needed
);
    logic [NUM_SLOTS-1:0] slot_is_fetch;

    genvar s;
    generate
        for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
            assign slot_is_fetch[s] = (type_codes[s*TYPE_W +: TYPE_W] == '0);
        end
    endgenerate

    assign check_needed = (|enables) && (|slot_is_fetch);
endmodule

// File: rtl/dbg_ctlsts_regs.sv
module dbg_ctlsts_regs
    import dbg_regs_pkg::*;
#(
    parameter bit NEWER_GEN = 1'b1,
    parameter int NUM_SLOTS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dbg_ext_en,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [2:0]  acc_index,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        acc_rvalid,
    output logic        fault_db,
    output logic        fault_ud,
    input  logic        exc_entry,
    input  logic [31:0] exc_events,
    input  logic        task_switch,
    input  logic        force_load,
    input  logic [31:0] force_value,
    output logic [31:0] ctl_value,
    output logic [31:0] sts_value,
    output logic        bp_check_needed
);
    localparam int TYPE_VEC_W = NUM_SLOTS * TYPE_W;

    regs_t regs_d, regs_q;
    word_t ctl_keep_mask, sts_take_mask, sts_reset_val;
    logic  grant, refuse_db, refuse_ud, hit_sts, hit_ctl;
    logic [TYPE_VEC_W-1:0] type_codes;

    dbg_gen_masks #(.NEWER_GEN(NEWER_GEN)) masks_i (
        .ctl_keep_mask (ctl_keep_mask),
        .sts_take_mask (sts_take_mask),
        .sts_reset_val (sts_reset_val)
    );

    dbg_port_decode decode_i (
        .acc_valid (acc_valid),
        .acc_index (acc_index),
        .lock_set  (regs_q.ctl[LOCK_BIT]),
        .ext_en    (dbg_ext_en),
        .grant     (grant),
        .refuse_db (refuse_db),
        .refuse_ud (refuse_ud),
        .hit_sts   (hit_sts),
        .hit_ctl   (hit_ctl)
    );

    genvar t;
    generate
        for (t = 0; t < NUM_SLOTS; t++) begin : g_type
            assign type_codes[t*TYPE_W +: TYPE_W] =
                regs_q.ctl[TYPE_LSB + t*TYPE_STRIDE +: TYPE_W];
        end
    endgenerate

    dbg_bp_watch #(.NUM_SLOTS(NUM_SLOTS)) watch_i (
        .enables      (regs_q.ctl[EN_BITS-1:0]),
        .type_codes   (type_codes),
        .check_needed (bp_check_needed)
    );

    always_comb begin
        regs_d          = regs_q;
        regs_d.rvalid   = 1'b0;
        regs_d.fault_db = 1'b0;
        regs_d.fault_ud = 1'b0;

        // step 1: port access
        if (refuse_db) begin
            regs_d.fault_db              = 1'b1;
            regs_d.sts[ACC_FLAG_BIT]     = 1'b1;
        end
        if (refuse_ud) begin
            regs_d.fault_ud = 1'b1;
        end
        if (grant && !acc_write) begin
            regs_d.rvalid = 1'b1;
            if (hit_sts)      regs_d.rdata = regs_q.sts;
            else if (hit_ctl) regs_d.rdata = regs_q.ctl;
            else              regs_d.rdata = '0;
        end
        if (grant && acc_write) begin
            if (hit_sts)
                regs_d.sts = (regs_q.sts & ~STS_FIELD_MASK) | (acc_wdata & sts_take_mask);
            if (hit_ctl)
                regs_d.ctl = (acc_wdata & ctl_keep_mask) | CTL_SET_ONES;
        end

        // step 2: exception entry
        if (exc_entry) begin
            regs_d.sts           = (regs_d.sts & ~STS_FIELD_MASK) | (exc_events & sts_take_mask);
            regs_d.ctl[LOCK_BIT] = 1'b0;
        end

        // step 3: task switch
        if (task_switch) begin
            regs_d.ctl = regs_d.ctl & ~TASK_CLR_MASK;
        end

        // step 4: forced load
        if (force_load) begin
            regs_d.ctl = (force_value & ctl_keep_mask) | CTL_SET_ONES;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctl      <= CTL_SET_ONES;
            regs_q.sts      <= sts_reset_val;
            regs_q.rdata    <= '0;
            regs_q.rvalid   <= 1'b0;
            regs_q.fault_db <= 1'b0;
            regs_q.fault_ud <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign acc_rdata  = regs_q.rdata;
    assign acc_rvalid = regs_q.rvalid;
    assign fault_db   = regs_q.fault_db;
    assign fault_ud   = regs_q.fault_ud;
    assign ctl_value  = regs_q.ctl;
    assign sts_value  = regs_q.sts;

    AST_CTL_BIT10_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_value[10] == 1'b1);  // R2
    AST_STS_FIXED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_value[31:16] == 16'hFFFF) && (sts_value[11:4] == 8'hFF));  // R3
    AST_LOCK_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ctl_value[LOCK_BIT] && !exc_entry)
            |=> (fault_db && !acc_rvalid && sts_value[ACC_FLAG_BIT]));  // R4
    AST_LOCK_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && ctl_value[LOCK_BIT] && !exc_entry && !task_switch && !force_load)
            |=> $stable(ctl_value));  // R4
    AST_EXC_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && !force_load) |=> !ctl_value[LOCK_BIT]);  // R5
    AST_TASK_CLEARS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (task_switch && !force_load) |=> ((ctl_value & TASK_CLR_MASK) == '0));  // R6
    AST_ALIAS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ctl_value[LOCK_BIT] && dbg_ext_en && (acc_index == 3'd4 || acc_index == 3'd5))
            |=> (fault_ud && !acc_rvalid));  // R7
    AST_FAULTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_db && fault_ud));  // R7

    generate
        if (NEWER_GEN) begin : g_newer_chk
            AST_CTL_HARDWIRED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl_value[15:14] == 2'b00) && !ctl_value[12]);  // R2
            AST_STS_BIT12_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                !sts_value[12]);  // R3
        end
    endgenerate
endmodule

// File: tb/dbg_ctlsts_regs_tb.sv
module dbg_ctlsts_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_ext_en = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [2:0]  acc_index = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_rvalid, fault_db, fault_ud;
    logic        exc_entry = 1'b0;
    logic [31:0] exc_events = '0;
    logic        task_switch = 1'b0;
    logic        force_load = 1'b0;
    logic [31:0] force_value = '0;
    logic [31:0] ctl_value, sts_value;
    logic        bp_check_needed;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_ctlsts_regs dut_i (
        .clk(clk), .rst_n(rst_n), .dbg_ext_en(dbg_ext_en),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_index(acc_index),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
        .fault_db(fault_db), .fault_ud(fault_ud),
        .exc_entry(exc_entry), .exc_events(exc_events),
        .task_switch(task_switch), .force_load(force_load), .force_value(force_value),
        .ctl_value(ctl_value), .sts_value(sts_value), .bp_check_needed(bp_check_needed)
    );

    // behavioural reference
    logic [31:0] m_ctl, m_sts, m_rd, n_ctl, n_sts;
    bit m_rv, m_db, m_ud;
    int idx;

    function automatic logic [31:0] ctl_clean(input logic [31:0] v);
        logic [31:0] r = v;
        r[15] = 1'b0; r[14] = 1'b0; r[12] = 1'b0; r[10] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] sts_merge(input logic [31:0] cur, input logic [31:0] v);
        return {cur[31:16], v[15:13], 1'b0, cur[11:4], v[3:0]};
    endfunction

    function automatic bit bp_ref(input logic [31:0] c);
        bit any_fetch = 0;
        for (int k = 0; k < 4; k++)
            if (c[16 + 4*k] == 1'b0 && c[17 + 4*k] == 1'b0) any_fetch = 1;
        return (c[7:0] != 0) && any_fetch;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = 32'h400; m_sts = 32'hFFFF0FF0; m_rd = 0;
            m_rv = 0; m_db = 0; m_ud = 0;
        end else begin
            n_ctl = m_ctl; n_sts = m_sts;
            m_rv = 0; m_db = 0; m_ud = 0;
            idx = int'(acc_index);
            if (acc_valid) begin
                if (m_ctl[13]) begin
                    m_db = 1; n_sts[13] = 1'b1;
                end else if (dbg_ext_en && (idx == 4 || idx == 5)) begin
                    m_ud = 1;
                end else if (!acc_write) begin
                    m_rv = 1;
                    case (idx)
                        4, 6:    m_rd = m_sts;
                        5, 7:    m_rd = m_ctl;
                        default: m_rd = 0;
                    endcase
                end else begin
                    if (idx == 4 || idx == 6) n_sts = sts_merge(m_sts, acc_wdata);
                    if (idx == 5 || idx == 7) n_ctl = ctl_clean(acc_wdata);
                end
            end
            if (exc_entry) begin
                n_sts = sts_merge(n_sts, exc_events);
                n_ctl[13] = 1'b0;
            end
            if (task_switch) begin
                n_ctl[0] = 0; n_ctl[2] = 0; n_ctl[4] = 0; n_ctl[6] = 0; n_ctl[8] = 0;
            end
            if (force_load) n_ctl = ctl_clean(force_value);
            m_ctl = n_ctl; m_sts = n_sts;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 ctl", ctl_value, m_ctl);
            chk("R3 sts", sts_value, m_sts);
            chk("R9 rdata", acc_rdata, m_rd);
            chk("R9 rvalid", {31'b0, acc_rvalid}, {31'b0, m_rv});
            chk("R4 fault_db", {31'b0, fault_db}, {31'b0, m_db});
            chk("R7 fault_ud", {31'b0, fault_ud}, {31'b0, m_ud});
            chk("R8 bp flag", {31'b0, bp_check_needed}, {31'b0, bp_ref(m_ctl)});
        end
    end

    task automatic idle();
        acc_valid = 0; acc_write = 0; exc_entry = 0; task_switch = 0; force_load = 0;
    endtask

    task automatic tick();
        @(negedge clk); #1;
        idle();
    endtask

    task automatic port(input bit wr, input int ix, input logic [31:0] d);
        acc_valid = 1; acc_write = wr; acc_index = 3'(ix); acc_wdata = d;
        tick();
    endtask

    task automatic unlock(input logic [31:0] ev);
        exc_entry = 1; exc_events = ev;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 ctl reset", ctl_value, 32'h00000400);
        chk("R1 sts reset", sts_value, 32'hFFFF0FF0);
        chk("R1 rdata reset", acc_rdata, 32'h0);
        chk("R1 flags reset", {28'b0, acc_rvalid, fault_db, fault_ud, bp_check_needed}, 32'h0);

        // R2 all-ones write to control sets the lock too
        port(1, 7, 32'hFFFFFFFF);
        chk("R2 ctl all ones", ctl_value, 32'hFFFF2FFF);
        // R4 locked read refused
        port(0, 6, 32'h0);
        chk("R4 db pulse", {31'b0, fault_db}, 32'h1);
        chk("R4 access flag", sts_value, 32'hFFFF2FF0);
        chk("R4 no rvalid", {31'b0, acc_rvalid}, 32'h0);
        // R4 locked index-4 access with extensions on still gives db, not ud
        dbg_ext_en = 1;
        port(1, 4, 32'h0);
        chk("R4 lock before alias", {30'b0, fault_db, fault_ud}, 32'h2);
        dbg_ext_en = 0;
        // R5 exception entry merges and unlocks
        unlock(32'h0000FFFF);
        chk("R5 sts merge", sts_value, 32'hFFFFEFFF);
        chk("R5 lock cleared", ctl_value, 32'hFFFF0FFF);

        // R8 breakpoint flag patterns
        port(1, 7, 32'h000000FF);
        chk("R8 type 00 with enables", {31'b0, bp_check_needed}, 32'h1);
        port(1, 7, 32'h333300FF);
        chk("R8 all types 11", {31'b0, bp_check_needed}, 32'h0);
        port(1, 7, 32'h33030001);
        chk("R8 slot1 fetch", {31'b0, bp_check_needed}, 32'h1);
        port(1, 7, 32'h33030000);
        chk("R8 no enables", {31'b0, bp_check_needed}, 32'h0);

        // R6 task switch
        port(1, 7, 32'h000007FF);
        task_switch = 1; tick();
        chk("R6 local clear", ctl_value, 32'h000006AA);

        // R3 status write
        port(1, 6, 32'hFFFFFFFF);
        chk("R3 sts all ones", sts_value, 32'hFFFFEFFF);
        port(1, 6, 32'h00000000);
        chk("R3 sts zeros", sts_value, 32'hFFFF0FF0);

        // R7 aliases
        port(1, 4, 32'h0000A005);
        chk("R7 alias4 write", sts_value, 32'hFFFFAFF5);
        port(0, 5, 32'h0);
        chk("R7 alias5 read", acc_rdata, 32'h000006AA);
        dbg_ext_en = 1;
        port(0, 4, 32'h0);
        chk("R7 ud pulse", {30'b0, fault_db, fault_ud}, 32'h1);
        port(1, 5, 32'h000000FF);
        chk("R7 ud no write", ctl_value, 32'h000006AA);
        dbg_ext_en = 0;

        // R9 address-register indices
        port(0, 2, 32'h0);
        chk("R9 idx2 read", acc_rdata, 32'h0);
        chk("R9 idx2 rvalid", {31'b0, acc_rvalid}, 32'h1);
        port(1, 1, 32'hFFFFFFFF);
        chk("R9 idx1 write ignored", ctl_value, 32'h000006AA);

        // R10 force-load under lock
        port(1, 7, 32'h00002000);
        force_load = 1; force_value = 32'hFFFFFFFF; tick();
        chk("R10 force under lock", ctl_value, 32'hFFFF2FFF);
        unlock(32'h0);

        // R11 write and task switch same cycle
        acc_valid = 1; acc_write = 1; acc_index = 3'd7; acc_wdata = 32'h000001FF;
        task_switch = 1; tick();
        chk("R11 write then switch", ctl_value, 32'h000004AA);
        // R11 locking write with exception entry same cycle
        acc_valid = 1; acc_write = 1; acc_index = 3'd7; acc_wdata = 32'h00002000;
        exc_entry = 1; exc_events = 32'h0; tick();
        chk("R11 write then exception", ctl_value, 32'h00000400);

        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            dbg_ext_en = ($urandom_range(0, 7) == 0);
            if (r < 55) begin
                acc_valid = 1; acc_write = $urandom_range(0, 1) == 1;
                acc_index = 3'($urandom_range(0, 7));
                acc_wdata = $urandom();
                if ($urandom_range(0, 3) != 0) acc_wdata[13] = 1'b0;
            end
            if (r >= 40 && r < 60) begin exc_entry = 1; exc_events = $urandom(); end
            if (r >= 50 && r < 65) task_switch = 1;
            if (r >= 60 && r < 66) begin force_load = 1; force_value = $urandom(); end
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule